// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This block sits between a synchronous serial shifter and the host side of a serial port. It holds the port's receive FIFO and transmit FIFO, each 16 words of 16 bits. It keeps the sticky and level flags that report how both queues are doing. The receive shifter pushes whole words and can also push a leftover byte. It also signals frame boundaries. The host pops received words and loads words to transmit. The transmit shifter pulls words out as it needs them.

The receiver enable does not switch off at once. After the enable is dropped, the receive path stays live until the second serial-clock strobe. Only then is the overflow flag forced clear. The other way to clear overflow is a clear strobe, and that strobe only acts when the receive FIFO is empty. The block has two residual-byte flags. Both are set by the same event, but they clear under different rules. All flags are packed into one read-only status word.

Top module: `ssp_fifo_flags`

## Requirements
- R1: Words pushed into the receive FIFO come out of the host read port in push order. The read data shows the head word while the FIFO is not empty, and it advances on a host pop. Transmit words leave the transmit read port in the same first-in first-out way.
- R2: A push into a full FIFO is dropped, and the 16 stored words are unchanged. A pop from an empty FIFO returns zero and does not move the pointers.
- R3: Status bit 0 (receive overflow) goes to 1 on the clock after the live receiver pushes a word or a residual byte while the receive FIFO holds 16 entries.
- R4: A pulse on `ovf_clr_wr` clears status bit 0 only when the receive FIFO is empty. The same pulse while the FIFO holds data leaves the bit set.
- R5: After `rx_enable` falls, the receiver stays live until the second `ser_tick` pulse. On the clock after that pulse, status bit 0 clears. While the receiver is not live, pushes are ignored and cannot set overflow. Raising `rx_enable` makes the receiver live again at once.
- R6: Status bit 1 (first residual flag) is set by `rx_resid_set`. It is cleared by a residual push (`rx_resid_push`) or by `rx_frame_sync`.
- R7: Status bit 2 (second residual flag) is set by `rx_resid_set` and cleared only by `rx_frame_sync`. A residual push leaves it set. If a set and a frame sync arrive in the same cycle, the set wins.
- R8: Status bit 3 (receive empty) is 1 exactly while the receive FIFO holds no entries.
- R9: Status bit 4 (transmit full) is 1 while the transmit FIFO holds 16 entries, and it drops after one entry is removed.
- R10: Status bit 5 (transmit underflow) is set on the clock after `tx_pop` arrives with the transmit FIFO empty. It clears on the next host load. A load in the same cycle takes priority.
- R11: After reset both FIFOs are empty and all sticky flags are clear, so the status word reads 0x0000_0008. Bits 31 to 6 always read 0.
- R12: A residual push stores the low byte of `rx_push_data` in the receive FIFO, zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable |
| ser_tick | input | 1 | One pulse per serial clock period |
| rx_push | input | 1 | Shifter pushes a full word |
| rx_resid_push | input | 1 | Shifter pushes a residual byte |
| rx_push_data | input | 16 | Word or byte (low 8 bits) from the shifter |
| rx_resid_set | input | 1 | A residual byte is pending |
| rx_frame_sync | input | 1 | New receive frame-sync pulse |
| host_rx_pop | input | 1 | Host pops the receive FIFO |
| host_rx_data | output | 16 | Receive FIFO head, zero when empty |
| host_tx_push | input | 1 | Host loads the transmit FIFO |
| host_tx_data | input | 16 | Word to load |
| tx_pop | input | 1 | Shifter requests a transmit word |
| tx_pop_data | output | 16 | Transmit FIFO head, zero when empty |
| ovf_clr_wr | input | 1 | Overflow-clear write strobe |
| status | output | 32 | Packed flag word |

## Verification
The hardest state to reach from the ports is the delayed clear of overflow through the enable. To get there, the bench fills the receive FIFO and forces an overflow. It then drops `rx_enable` and sends `ser_tick` pulses one at a time. After the first pulse it checks that overflow still holds. After the second it checks that the flag clears one clock later. It then pushes into the still-full FIFO to show the dead receiver cannot set overflow again. The clear-strobe path is tested both before and after draining the FIFO, so its dependence on the empty state is seen directly.

// File: rtl/ssp_flags_pkg.sv
package ssp_flags_pkg;
  localparam int unsigned FLAG_W = 6;

  // Field order fixes the bit positions: last field is bit 0.
  typedef struct packed {
    logic tx_undf;   // bit 5
    logic tx_full;   // bit 4
    logic rx_empty;  // bit 3
    logic resid_b;   // bit 2
    logic resid_a;   // bit 1
    logic rx_ovf;    // bit 0
  } flag_vec_t;
endpackage

// File: rtl/ssp_sync_fifo.sv
module ssp_sync_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign pop_data = empty ? '0 : mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  // R2
  fifo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> full && $stable(rd_q));
  // R2
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push |=> empty && $stable(rd_q));
  // R8
  fifo_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

// File: rtl/ssp_rx_flags.sv
module ssp_rx_flags #(
  parameter int unsigned DIS_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_enable,
  input  logic ser_tick,
  input  logic push_req,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic ovf_clr_wr,
  input  logic resid_set,
  input  logic resid_push,
  input  logic frame_sync,
  output logic rx_active,
  output logic rx_ovf,
  output logic resid_a,
  output logic resid_b
);
  localparam int unsigned TW = $clog2(DIS_TICKS + 1);
  localparam logic [TW-1:0] TLAST = TW'(DIS_TICKS - 1);

  logic          on_q, on_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          ovf_d, ra_d, rb_d;
  logic          ovf_q, ra_q, rb_q;

  assign rx_active = rx_enable | on_q;
  assign rx_ovf    = ovf_q;
  assign resid_a   = ra_q;
  assign resid_b   = rb_q;

  always_comb begin
    on_d   = on_q;
    tcnt_d = tcnt_q;
    if (rx_enable) begin
      on_d   = 1'b1;
      tcnt_d = '0;
    end else if (on_q && ser_tick) begin
      if (tcnt_q == TLAST) begin
        on_d   = 1'b0;
        tcnt_d = '0;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    ovf_d = ovf_q;
    if (rx_active && push_req && fifo_full) ovf_d = 1'b1;
    else if (!rx_active)                    ovf_d = 1'b0;
    else if (ovf_clr_wr && fifo_empty)      ovf_d = 1'b0;

    ra_d = ra_q;
    rb_d = rb_q;
    if (resid_set) begin
      ra_d = 1'b1;
      rb_d = 1'b1;
    end else begin
      if (frame_sync || resid_push) ra_d = 1'b0;
      if (frame_sync)               rb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      tcnt_q <= '0;
      ovf_q  <= 1'b0;
      ra_q   <= 1'b0;
      rb_q   <= 1'b0;
    end else begin
      on_q   <= on_d;
      tcnt_q <= tcnt_d;
      ovf_q  <= ovf_d;
      ra_q   <= ra_d;
      rb_q   <= rb_d;
    end
  end

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active && push_req && fifo_full |=> rx_ovf);
  // R4
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf && !fifo_empty && rx_enable |=> rx_ovf);
  // R5
  ovf_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> !rx_ovf);
  // R6
  resid_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !resid_set |=> !resid_a && !resid_b);
  // R7
  resid_b_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resid_b && !frame_sync |=> resid_b);
endmodule

// File: rtl/ssp_fifo_flags.sv
module ssp_fifo_flags
  import ssp_flags_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned WIDTH     = 16,
  parameter int unsigned RESID_W   = 8,
  parameter int unsigned DIS_TICKS = 2,
  parameter int unsigned STAT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              ser_tick,
  input  logic              rx_push,
  input  logic              rx_resid_push,
  input  logic [WIDTH-1:0]  rx_push_data,
  input  logic              rx_resid_set,
  input  logic              rx_frame_sync,
  input  logic              host_rx_pop,
  output logic [WIDTH-1:0]  host_rx_data,
  input  logic              host_tx_push,
  input  logic [WIDTH-1:0]  host_tx_data,
  input  logic              tx_pop,
  output logic [WIDTH-1:0]  tx_pop_data,
  input  logic              ovf_clr_wr,
  output logic [STAT_W-1:0] status
);
  logic             rx_active, rx_any_push, rx_fifo_push;
  logic [WIDTH-1:0] rx_wdata;
  logic             rx_empty, rx_full, tx_empty, tx_full;
  logic             rx_ovf, resid_a, resid_b;
  logic             undf_q, undf_d;
  flag_vec_t        flags;

  assign rx_any_push  = rx_push | rx_resid_push;
  assign rx_fifo_push = rx_active & rx_any_push;
  assign rx_wdata     = rx_resid_push ? {{(WIDTH-RESID_W){1'b0}}, rx_push_data[RESID_W-1:0]}
                                      : rx_push_data;

  ssp_sync_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_fifo_push), .push_data(rx_wdata),
    .pop(host_rx_pop), .pop_data(host_rx_data),
    .empty(rx_empty), .full(rx_full)
  );

  ssp_sync_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(host_tx_push), .push_data(host_tx_data),
    .pop(tx_pop), .pop_data(tx_pop_data),
    .empty(tx_empty), .full(tx_full)
  );

  ssp_rx_flags #(.DIS_TICKS(DIS_TICKS)) u_rx_flags (
    .clk(clk), .rst_n(rst_n),
    .rx_enable(rx_enable), .ser_tick(ser_tick),
    .push_req(rx_any_push), .fifo_full(rx_full), .fifo_empty(rx_empty),
    .ovf_clr_wr(ovf_clr_wr),
    .resid_set(rx_resid_set), .resid_push(rx_resid_push & rx_active),
    .frame_sync(rx_frame_sync),
    .rx_active(rx_active), .rx_ovf(rx_ovf),
    .resid_a(resid_a), .resid_b(resid_b)
  );

  always_comb begin
    undf_d = undf_q;
    if (host_tx_push)           undf_d = 1'b0;
    else if (tx_pop && tx_empty) undf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) undf_q <= 1'b0;
    else        undf_q <= undf_d;
  end

  always_comb begin
    flags.tx_undf  = undf_q;
    flags.tx_full  = tx_full;
    flags.rx_empty = rx_empty;
    flags.resid_b  = resid_b;
    flags.resid_a  = resid_a;
    flags.rx_ovf   = rx_ovf;
    status = {{(STAT_W-FLAG_W){1'b0}}, flags};
  end

  // R10
  tx_undf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_empty && !host_tx_push |=> status[5]);
  // R10
  tx_undf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_push |=> !status[5]);
  // R11
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[STAT_W-1:FLAG_W] == '0);
endmodule

// File: tb/sim_ssp_fifo_flags.sv
`timescale 1ns/1ps
module sim_ssp_fifo_flags;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_enable, ser_tick, rx_push, rx_resid_push, rx_resid_set, rx_frame_sync;
  logic [15:0] rx_push_data, host_tx_data;
  logic        host_rx_pop, host_tx_push, tx_pop, ovf_clr_wr;
  logic [15:0] host_rx_data, tx_pop_data;
  logic [31:0] status;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] rxq[$];
  logic [15:0] txq[$];

  always #10 clk = ~clk;

  ssp_fifo_flags u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ser_tick(ser_tick),
    .rx_push(rx_push), .rx_resid_push(rx_resid_push), .rx_push_data(rx_push_data),
    .rx_resid_set(rx_resid_set), .rx_frame_sync(rx_frame_sync),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .ovf_clr_wr(ovf_clr_wr), .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic rx_word(input logic [15:0] d, input bit live);
    rx_push = 1'b1; rx_push_data = d;
    if (live && rxq.size() < 16) rxq.push_back(d);
    tick(); rx_push = 1'b0;
  endtask

  task automatic rx_resid(input logic [15:0] d);
    rx_resid_push = 1'b1; rx_push_data = d;
    if (rxq.size() < 16) rxq.push_back({8'h00, d[7:0]});
    tick(); rx_resid_push = 1'b0;
  endtask

  task automatic host_read();
    host_rx_pop = 1'b1; tick(); host_rx_pop = 1'b0;
  endtask

  task automatic tx_load(input logic [15:0] d);
    host_tx_push = 1'b1; host_tx_data = d;
    if (txq.size() < 16) txq.push_back(d);
    tick(); host_tx_push = 1'b0;
  endtask

  task automatic tx_take();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  // Monitor: compares pop data against the scoreboard queues before the edge.
  always begin
    logic [15:0] e;
    @(negedge clk); #5;
    if (rst_n && host_rx_pop) begin
      e = (rxq.size() > 0) ? rxq.pop_front() : 16'h0000;
      check(host_rx_data == e, "R1/R2 rx data", {16'h0, host_rx_data}, {16'h0, e});
    end
    if (rst_n && tx_pop) begin
      e = (txq.size() > 0) ? txq.pop_front() : 16'h0000;
      check(tx_pop_data == e, "R1/R2 tx data", {16'h0, tx_pop_data}, {16'h0, e});
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_enable = 1'b0; ser_tick = 1'b0; rx_push = 1'b0; rx_resid_push = 1'b0;
    rx_resid_set = 1'b0; rx_frame_sync = 1'b0; rx_push_data = '0; host_tx_data = '0;
    host_rx_pop = 1'b0; host_tx_push = 1'b0; tx_pop = 1'b0; ovf_clr_wr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    check(status == 32'h8, "R11 reset status", status, 32'h8);
    check(host_rx_data == 16'h0, "R2 empty read", {16'h0, host_rx_data}, 32'h0);
    rx_enable = 1'b1;

    // R1 ordering, R8 empty level
    rx_word(16'h1111, 1); rx_word(16'h2222, 1); rx_word(16'h3333, 1);
    check(status[3] == 1'b0, "R8 not empty", status, 32'h0);
    repeat (3) host_read();
    check(status[3] == 1'b1, "R8 empty again", status, 32'h8);

    // R3 overflow, R2 drop
    for (int i = 0; i < 16; i++) rx_word(16'hA000 + 16'(i), 1);
    check(status[3:0] == 4'b0000, "R8 full rx", status, 32'h0);
    rx_word(16'hDEAD, 1);
    check(status[0] == 1'b1, "R3 overflow set", status, 32'h1);
    // R4 clear ignored when not empty
    ovf_clr_wr = 1'b1; tick(); ovf_clr_wr = 1'b0;
    check(status[0] == 1'b1, "R4 clear ignored", status, 32'h1);
    for (int i = 0; i < 16; i++) host_read();
    host_read(); // R2 pop from empty returns zero
    check(status[0] == 1'b1, "R4 still set after drain", status, 32'h9);
    ovf_clr_wr = 1'b1; tick(); ovf_clr_wr = 1'b0;
    check(status == 32'h8, "R4 clear after drain", status, 32'h8);

    // R5 delayed disable clear
    for (int i = 0; i < 17; i++) rx_word(16'hB000 + 16'(i), 1);
    check(status[0] == 1'b1, "R3 overflow again", status, 32'h1);
    rx_enable = 1'b0; tick();
    check(status[0] == 1'b1, "R5 no tick yet", status, 32'h1);
    ser_tick = 1'b1; tick(); ser_tick = 1'b0;
    check(status[0] == 1'b1, "R5 one tick", status, 32'h1);
    ser_tick = 1'b1; tick(); ser_tick = 1'b0;
    tick();
    check(status[0] == 1'b0, "R5 cleared by disable", status, 32'h0);
    rx_word(16'hCAFE, 0); tick();
    check(status[0] == 1'b0, "R5 dead push no overflow", status, 32'h0);
    rx_enable = 1'b1;
    for (int i = 0; i < 16; i++) host_read();
    rx_enable = 1'b0;
    ser_tick = 1'b1; tick(); tick(); ser_tick = 1'b0;
    rx_word(16'h5555, 0);
    check(status[3] == 1'b1, "R5 dead push ignored", status, 32'h8);
    rx_enable = 1'b1;

    // R6 / R7 / R12 residual flags
    rx_resid_set = 1'b1; tick(); rx_resid_set = 1'b0;
    check(status[2:1] == 2'b11, "R6 R7 set", status, 32'he);
    rx_resid(16'hABCD);
    check(status[2:1] == 2'b10, "R6 R7 resid push", status, 32'h4);
    host_read(); // R12 expects 0x00CD
    rx_frame_sync = 1'b1; tick(); rx_frame_sync = 1'b0;
    check(status[2:1] == 2'b00, "R7 frame sync", status, 32'h0);
    rx_resid_set = 1'b1; tick(); rx_resid_set = 1'b0;
    rx_frame_sync = 1'b1; tick(); rx_frame_sync = 1'b0;
    check(status[2:1] == 2'b00, "R6 frame sync", status, 32'h0);
    rx_resid_set = 1'b1; rx_frame_sync = 1'b1; tick(); rx_resid_set = 1'b0; rx_frame_sync = 1'b0;
    check(status[2:1] == 2'b11, "R7 set wins", status, 32'h6);
    rx_frame_sync = 1'b1; tick(); rx_frame_sync = 1'b0;

    // R10 underflow, R9 full
    tx_take();
    check(status[5] == 1'b1, "R10 underflow set", status, 32'h20);
    tx_load(16'h0100);
    check(status[5] == 1'b0, "R10 cleared by load", status, 32'h0);
    for (int i = 1; i < 16; i++) tx_load(16'h0100 + 16'(i));
    check(status[4] == 1'b1, "R9 tx full", status, 32'h10);
    tx_load(16'hFFFF);
    tx_take();
    check(status[4] == 1'b0, "R9 full drops", status, 32'h0);
    for (int i = 0; i < 15; i++) tx_take();
    check(status[5] == 1'b0, "R10 no underflow", status, 32'h0);
    tx_take();
    check(status[5] == 1'b1, "R10 underflow again", status, 32'h20);
    check(status[31:6] == '0, "R11 upper bits", status, 32'h0);

    tick();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule